// File: doc/BRIEF.md
# Brake Input Conditioner

This block turns one of four asynchronous external brake pins into a clean brake indication for a PWM generator. A 2-bit source field picks the pin. A two-flop synchronizer brings the pin into the clock domain, and a polarity bit can invert it so that the active level is always high inside the block. The result then passes through a noise filter, or goes straight through when the filter is switched off.

The filter samples its input on strobes from a free-running prescaler. The prescaler divides the clock by 2 to the power of a 3-bit select field. A 3-bit count field sets how many consecutive differing samples it takes before the filtered level changes. When the filtered level goes from inactive to active, the block raises a single-cycle brake event. The filtered level and the event pulse are the only outputs.

Top module: `brk_filter`

## Requirements
- R1: During and right after reset, `brk_level` and `brk_event` are 0. The prescaler counter and the stability counter start at zero.
- R2: `src_sel` is a 2-bit index. Value n selects `brk_pins[n]` as the brake source.
- R3: With `pol_inv` = 0, a high pin is active and gives `brk_level` = 1. With `pol_inv` = 1, a low pin is active.
- R4: With `filt_en` = 0, `brk_level` takes the synchronized, polarity-corrected pin on every clock, with no filtering.
- R5: With `filt_en` = 1, the filter samples only on strobe cycles. A strobe occurs when the low `div_sel` bits of a free-running counter (reset to 0, +1 per clock) are all zero, so one clock in every 2^`div_sel` is a strobe. `brk_level` never changes after a non-strobe cycle.
- R6: With `filt_en` = 1, `brk_level` changes only after `stable_cnt`+1 consecutive strobe samples differ from it. Any strobe sample equal to `brk_level` clears the count, so shorter glitches are dropped.
- R7: `brk_event` is high for exactly one clock, in the cycle after `brk_level` rises from 0 to 1. A fall of `brk_level` gives no event.
- R8: The pin goes through two flops before the source mux. In bypass mode, a pin change that is set up before clock edge k shows on `brk_level` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_pins | input | 4 | Raw external brake pins |
| src_sel | input | 2 | Selects the brake pin |
| filt_en | input | 1 | 1 turns the noise filter on, 0 bypasses it |
| div_sel | input | 3 | Sampling strobe period is 2^div_sel clocks |
| stable_cnt | input | 3 | Number of differing samples required, minus one |
| pol_inv | input | 1 | 1 makes a low pin the active level |
| brk_level | output | 1 | Filtered, polarity-corrected brake level |
| brk_event | output | 1 | One-clock pulse when the brake becomes active |

## Verification
A wrong stability count or prescaler phase moves the edge of `brk_level`. The level then toggles one or more strobe periods early or late, or a short glitch gets through. The scoreboard catches this on the first clock where `brk_level` differs from the reference. A stale event register shows up as a missing pulse or a pulse of two clocks, in the cycle after the level rises. A synchronizer of the wrong depth shifts every bypass transition by a clock, and this is caught at the first pin change.

// File: rtl/brk_filter.sv
module brk_filter #(
  parameter int NPIN  = 4,
  parameter int SEL_W = 2,
  parameter int DIV_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  brk_pins,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             filt_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [CNT_W-1:0] stable_cnt,
  input  logic             pol_inv,
  output logic             brk_level,
  output logic             brk_event
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [NPIN-1:0]  sync1, sync2;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;
  logic [CNT_W-1:0] cnt;
  logic             lvl_d;
  logic             sel;
  logic             tick;

  assign sel      = sync2[src_sel] ^ pol_inv;
  assign pre_mask = (PRE_W'(1) << div_sel) - PRE_W'(1);
  assign tick     = (pre_cnt & pre_mask) == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      pre_cnt <= '0;
    end else begin
      sync1   <= brk_pins;
      sync2   <= sync1;
      pre_cnt <= pre_cnt + PRE_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      brk_level <= 1'b0;
      cnt       <= '0;
    end else if (!filt_en) begin
      brk_level <= sel;
      cnt       <= '0;
    end else if (tick) begin
      if (sel == brk_level) begin
        cnt <= '0;
      end else if (cnt == stable_cnt) begin
        brk_level <= sel;
        cnt       <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= brk_level;

  assign brk_event = brk_level & ~lvl_d;
endmodule

// File: rtl/brk_filter_chk.sv
module brk_filter_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             filt_en,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] stable_cnt,
  input logic             brk_level,
  input logic             brk_event
);
  AST_EVENT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    brk_event |=> !brk_event); // R7
  AST_EVENT_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    brk_event |-> brk_level); // R7
  AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && !tick) |=> $stable(brk_level)); // R5
  AST_HOLD_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && tick && cnt != stable_cnt) |=> $stable(brk_level)); // R6
endmodule

bind brk_filter brk_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .tick(tick), .cnt(cnt),
  .stable_cnt(stable_cnt), .brk_level(brk_level), .brk_event(brk_event));

// File: tb/brk_filter_tb.sv
module brk_filter_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] brk_pins = '0;
  logic [1:0] src_sel = '0;
  logic filt_en = 0, pol_inv = 0;
  logic [2:0] div_sel = '0, stable_cnt = '0;
  logic brk_level, brk_event;
  int n_chk = 0, n_fail = 0;
  string req = "R1";
  logic [1:0] exp_q[$];
  int ev_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brk_filter u_dut (.clk(clk), .rst_n(rst_n), .brk_pins(brk_pins), .src_sel(src_sel),
    .filt_en(filt_en), .div_sel(div_sel), .stable_cnt(stable_cnt), .pol_inv(pol_inv),
    .brk_level(brk_level), .brk_event(brk_event));

  // reference model: expected items pushed each clock
  logic [3:0] ms1, ms2;
  logic [6:0] mpre;
  logic [2:0] mcnt;
  logic mlvl, mprev, msel, mtick;
  always @(posedge clk) begin
    if (!rst_n) begin
      ms1 = '0; ms2 = '0; mpre = '0; mcnt = '0; mlvl = 0; mprev = 0;
    end else begin
      msel  = ms2[src_sel] ^ pol_inv;
      mtick = (mpre & ((7'd1 << div_sel) - 7'd1)) == 7'd0;
      mprev = mlvl;
      if (!filt_en) begin mlvl = msel; mcnt = 0; end
      else if (mtick) begin
        if (msel == mlvl) mcnt = 0;
        else if (mcnt == stable_cnt) begin mlvl = msel; mcnt = 0; end
        else mcnt = mcnt + 3'd1;
      end
      ms2 = ms1; ms1 = brk_pins; mpre = mpre + 7'd1;
    end
    exp_q.push_back({mlvl, mlvl & ~mprev});
  end

  // monitor
  always @(negedge clk) begin
    if (brk_event) ev_seen++;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      e = exp_q.pop_front();
      n_chk++;
      if ({brk_level, brk_event} !== e) begin
        n_fail++;
        $display("FAIL %s scoreboard: got lvl=%b ev=%b expected lvl=%b ev=%b",
                 req, brk_level, brk_event, e[1], e[0]);
      end
    end
  end

  task automatic check(string r, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", r, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check("R1 level in reset", brk_level, 0);
    check("R1 event in reset", brk_event, 0);
    rst_n = 1;
    cyc(1);
    check("R1 level after reset", brk_level, 0);

    req = "R8";
    brk_pins = 4'b0001; cyc(2);
    check("R8 level after two edges", brk_level, 0);
    cyc(1);
    check("R8 level after third edge", brk_level, 1);
    req = "R7";
    check("R7 event on rise", brk_event, 1);
    cyc(1);
    check("R7 event cleared", brk_event, 0);
    ev_seen = 0;
    brk_pins = 4'b0000; cyc(5);
    check("R7 no event on fall", ev_seen == 0, 1);

    req = "R2";
    brk_pins = 4'b0100; src_sel = 2; cyc(4);
    check("R2 pin2 selected", brk_level, 1);
    src_sel = 0; cyc(2);
    check("R2 pin0 selected", brk_level, 0);

    req = "R3";
    pol_inv = 1; cyc(2);
    check("R3 inverted low pin active", brk_level, 1);
    pol_inv = 0; cyc(2);

    req = "R6";
    filt_en = 1; div_sel = 0; stable_cnt = 3; src_sel = 1;
    cyc(3);
    brk_pins = 4'b0010; cyc(2); brk_pins = 4'b0000; cyc(10);
    check("R6 short glitch dropped", brk_level, 0);
    brk_pins = 4'b0010; cyc(12);
    check("R6 long pulse accepted", brk_level, 1);

    req = "R5";
    div_sel = 2; stable_cnt = 1;
    for (int i = 0; i < 600; i++) begin
      if (i % 7 == 0) brk_pins = 4'($urandom);
      if (i == 300) begin div_sel = 3; stable_cnt = 0; end
      cyc(1);
    end

    req = "R4";
    filt_en = 0;
    for (int i = 0; i < 300; i++) begin
      brk_pins = 4'($urandom);
      if (i % 40 == 0) begin src_sel = 2'($urandom); pol_inv = 1'($urandom); end
      cyc(1);
    end

    req = "R6";
    filt_en = 1; div_sel = 1;
    for (int i = 0; i < 800; i++) begin
      if (i % 100 == 0) stable_cnt = 3'($urandom);
      if ($urandom % 5 == 0) brk_pins = 4'($urandom);
      cyc(1);
    end

    req = "R1";
    rst_n = 0; cyc(2);
    check("R1 level after mid-run reset", brk_level, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule